// File: doc/BRIEF.md
# Snooze Entry and Exit Sequencer for a Pipelined Synchronous SRAM

This block sits between a memory controller's command stream and a pipelined synchronous SRAM that offers an active-high snooze (low-power, data-retaining) pin. While the host runs normally, commands pass straight through to the memory. When the host asks for sleep, the sequencer stops accepting commands and issues deselect cycles until the two-stage read/write pipeline inside the memory has emptied. Only then does it raise the snooze pin, and it holds the pin for as long as the request stays high.

On wake the pin drops at once. The memory then needs a short recovery period in which it may receive only deselect or read cycles. The sequencer therefore lets reads through during that window and stalls writes by holding `ready` low. The host keeps any stalled command on its inputs until `ready` is high. After the window ends, full operation resumes. If the sleep request is withdrawn while the pipeline is still draining, the sequencer returns to normal operation and never raises the pin.

Top module: `snooze_sequencer`

## Requirements
- R1: After a synchronous active-low reset, `mem_snooze` is 0, the sequencer is in normal operation, and `ready` is 1 while `sleep_req` is 0.
- R2: In normal operation with `sleep_req` low, `ready` is 1 and `mem_sel` equals `cmd_valid` in the same cycle. `mem_sel`=1 means an active cycle and `mem_sel`=0 means a deselect.
- R3: `mem_addr` always equals `cmd_addr`. `mem_wr` (1 = write, 0 = read) equals `cmd_wr` whenever `mem_sel` is 1 and is 0 whenever `mem_sel` is 0.
- R4: In the first cycle in which `sleep_req` is seen high during normal operation, `ready` and `mem_sel` are 0 in that same cycle, whatever command is presented.
- R5: `mem_snooze` rises only after DRAIN_CYC (default 2) consecutive deselect cycles have been issued. With `sleep_req` held high from the first cycle, it is 1 in the cycle after the DRAIN_CYC-th deselect cycle.
- R6: While `mem_snooze` is 1, `mem_sel` and `ready` are 0 for any command.
- R7: If `sleep_req` falls before the drain completes, `mem_snooze` stays 0 and normal operation, with `ready`=1, resumes in the next cycle.
- R8: When `sleep_req` falls while `mem_snooze` is 1, `mem_snooze` is 0 from the next cycle on.
- R9: During the REC_CYC (default 2) cycles that follow the release of the pin, a write request sees `ready`=0 and `mem_sel`=0. A read request sees `ready`=1 and `mem_sel`=1.
- R10: In the cycle after the recovery window ends, a write request is accepted with `ready`=1, `mem_sel`=1 and `mem_wr`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_req | input | 1 | Host request for snooze; held high for as long as sleep is wanted |
| cmd_valid | input | 1 | Host presents a command |
| cmd_wr | input | 1 | Command kind: 1 write, 0 read |
| cmd_addr | input | AW | Command address |
| ready | output | 1 | The presented command is accepted this cycle |
| mem_sel | output | 1 | Memory cycle select: 1 active cycle, 0 deselect |
| mem_wr | output | 1 | Memory cycle kind: 1 write, 0 read |
| mem_addr | output | AW | Memory address |
| mem_snooze | output | 1 | Active-high snooze pin to the memory |

## Verification
The bench targets the exact cycle in which the snooze pin rises. A design that counted one deselect short would put the memory to sleep with an operation still in flight, and one that ignored the request for a cycle would let a last command slip into the drain. It also checks each cycle of the recovery window separately for writes and reads: an off-by-one window would either let a write reach a memory that is still waking or stall the host one cycle too long. A request withdrawn during the drain must not pulse the pin. A reset in the middle of a sleep must release the pin, and a design that kept the pin or its state across reset would leave the memory asleep.

// File: rtl/snz_pkg.sv
`timescale 1ns/1ps
// Shared types for the snooze sequencer.
package snz_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,  // normal pass-through
        ST_DRAIN = 2'd1,  // issuing deselects until the pipeline is empty
        ST_SLEEP = 2'd2,  // snooze pin held high
        ST_WAKE  = 2'd3   // recovery window: reads only
    } snz_state_t;
endpackage

// File: rtl/snz_ctrl.sv
`timescale 1ns/1ps
// Sequencing state machine. It tracks the drain and recovery windows with
// one shared counter and drives the registered snooze pin.
// Assumes DRAIN_CYC >= 2 and REC_CYC >= 1. The first drain deselect is
// issued in the run cycle that first sees sleep_req.
module snz_ctrl
    import snz_pkg::*;
#(
    parameter int DRAIN_CYC = 2,
    parameter int REC_CYC   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    output snz_state_t state,
    output logic       snooze
);
    localparam int MAXC = (DRAIN_CYC > REC_CYC) ? DRAIN_CYC : REC_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    snz_state_t        nxt;
    logic [CW-1:0]     cnt_q, cnt_d;

    // Next-state and window counter selection.
    always_comb begin
        nxt   = state;
        cnt_d = cnt_q;
        unique case (state)
            ST_RUN: if (sleep_req) begin
                nxt   = ST_DRAIN;
                cnt_d = CW'(1);
            end
            ST_DRAIN: begin
                if (!sleep_req) begin
                    nxt = ST_RUN;
                end else if (cnt_q == CW'(DRAIN_CYC - 1)) begin
                    nxt = ST_SLEEP;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            ST_SLEEP: if (!sleep_req) begin
                nxt   = ST_WAKE;
                cnt_d = '0;
            end
            ST_WAKE: begin
                if (cnt_q == CW'(REC_CYC - 1)) begin
                    nxt = ST_RUN;
                end else begin
                    cnt_d = cnt_q + CW'(1);
                end
            end
            default: nxt = ST_RUN;
        endcase
    end

    // State, counter and snooze pin registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_RUN;
            cnt_q  <= '0;
            snooze <= 1'b0;
        end else begin
            state  <= nxt;
            cnt_q  <= cnt_d;
            snooze <= (nxt == ST_SLEEP);
        end
    end

    // R5
    snooze_needs_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(snooze) |-> $past(sleep_req));

    // R8
    snooze_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snooze && !sleep_req) |=> !snooze);
endmodule

// File: rtl/snz_cmd_gate.sv
`timescale 1ns/1ps
// Command gate. It passes host commands to the memory or replaces them with
// deselects, according to the sequencer state. Purely combinational.
// Assumes the host holds a command stable while ready is low.
module snz_cmd_gate
    import snz_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  snz_state_t    state,
    input  logic          sleep_req,
    input  logic          cmd_valid,
    input  logic          cmd_wr,
    input  logic [AW-1:0] cmd_addr,
    output logic          ready,
    output logic          mem_sel,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr
);
    // Acceptance decision for the presented command.
    always_comb begin
        unique case (state)
            ST_RUN:   ready = !sleep_req;
            ST_WAKE:  ready = !cmd_wr;
            default:  ready = 1'b0;
        endcase
    end

    // Memory-side command: a deselect unless the command is accepted.
    always_comb begin
        mem_sel  = cmd_valid && ready;
        mem_wr   = mem_sel && cmd_wr;
        mem_addr = cmd_addr;
    end

    // R9
    wake_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAKE && cmd_wr) |-> !mem_sel);

    // R4
    stalled_cmd_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !ready) |-> !mem_sel);
endmodule

// File: rtl/snooze_sequencer.sv
`timescale 1ns/1ps
// Snooze entry/exit sequencer for a pipelined synchronous SRAM.
// It drains the memory pipeline with deselects before raising the snooze
// pin, and on wake it allows only reads for REC_CYC cycles.
// Assumes the host retries any command presented while ready is low.
module snooze_sequencer
    import snz_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DRAIN_CYC = 2,
    parameter int REC_CYC   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sleep_req,
    input  logic          cmd_valid,
    input  logic          cmd_wr,
    input  logic [AW-1:0] cmd_addr,
    output logic          ready,
    output logic          mem_sel,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic          mem_snooze
);
    localparam int IW = $clog2(DRAIN_CYC + 1);
    localparam int WW = $clog2(REC_CYC + 1);

    snz_state_t state;

    snz_ctrl #(.DRAIN_CYC(DRAIN_CYC), .REC_CYC(REC_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_req (sleep_req),
        .state     (state),
        .snooze    (mem_snooze)
    );

    snz_cmd_gate #(.AW(AW)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .sleep_req (sleep_req),
        .cmd_valid (cmd_valid),
        .cmd_wr    (cmd_wr),
        .cmd_addr  (cmd_addr),
        .ready     (ready),
        .mem_sel   (mem_sel),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr)
    );

    // Checker support: consecutive deselect cycles, saturating at DRAIN_CYC.
    logic [IW-1:0] idle_run;
    always_ff @(posedge clk) begin
        if (!rst_n)                        idle_run <= '0;
        else if (mem_sel)                  idle_run <= '0;
        else if (idle_run != IW'(DRAIN_CYC)) idle_run <= idle_run + IW'(1);
    end

    // Checker support: cycles since the snooze pin was released.
    logic [WW-1:0] wake_age;
    always_ff @(posedge clk) begin
        if (!rst_n)                        wake_age <= WW'(REC_CYC);
        else if (mem_snooze)               wake_age <= '0;
        else if (wake_age != WW'(REC_CYC)) wake_age <= wake_age + WW'(1);
    end

    // R5
    drain_before_snooze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_snooze) |-> (idle_run == IW'(DRAIN_CYC)));

    // R6
    quiet_in_snooze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_snooze |-> (!mem_sel && !ready));

    // R9
    no_write_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_snooze && wake_age != WW'(REC_CYC)) |-> !(mem_sel && mem_wr));

    // R3
    addr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr == cmd_addr) && (mem_sel || !mem_wr));
endmodule

// File: tb/snooze_sequencer_tb.sv
`timescale 1ns/1ps
module snooze_sequencer_tb;
    localparam int AW = 20;
    localparam int NV = 8;
    // Each entry: {cmd_valid, cmd_wr, cmd_addr}
    localparam logic [AW+1:0] VEC [NV] = '{
        {1'b1, 1'b0, 20'h00000}, {1'b1, 1'b1, 20'hFFFFF},
        {1'b0, 1'b1, 20'h12345}, {1'b0, 1'b0, 20'hABCDE},
        {1'b1, 1'b1, 20'h55555}, {1'b1, 1'b0, 20'hAAAAA},
        {1'b0, 1'b0, 20'h00001}, {1'b1, 1'b1, 20'h80000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_wr = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic ready, mem_sel, mem_wr, mem_snooze;
    logic [AW-1:0] mem_addr;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    snooze_sequencer #(.AW(AW), .DRAIN_CYC(2), .REC_CYC(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req),
        .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
        .ready(ready), .mem_sel(mem_sel), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_snooze(mem_snooze)
    );

    task automatic chk(input int got, input int exp, input string what);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", what, got, exp);
        end
    endtask

    task automatic drive(input logic v, input logic w, input logic [AW-1:0] a);
        cmd_valid = v; cmd_wr = w; cmd_addr = a;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(mem_snooze, 0, "R1 reset snooze");
        chk(ready, 1, "R1 reset ready");
        rst_n = 1'b1;

        // Table walk: normal pass-through (R2, R3)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][AW+1], VEC[i][AW], VEC[i][AW-1:0]);
            chk(ready, 1, "R2 run ready");
            chk(mem_sel, VEC[i][AW+1], "R2 run mem_sel");
            chk(mem_wr, VEC[i][AW+1] & VEC[i][AW], "R3 mem_wr");
            chk(int'(mem_addr), int'(VEC[i][AW-1:0]), "R3 mem_addr");
        end

        // Sleep entry (R4, R5, R6)
        @(negedge clk);
        sleep_req = 1'b1; drive(1'b1, 1'b1, 20'h00010);
        chk(ready, 0, "R4 ready on request");
        chk(mem_sel, 0, "R4 deselect on request");
        chk(mem_snooze, 0, "R5 no snooze in drain 1");
        @(negedge clk); drive(1'b1, 1'b0, 20'h00011);
        chk(mem_sel, 0, "R5 drain deselect 2");
        chk(mem_snooze, 0, "R5 no snooze in drain 2");
        @(negedge clk); drive(1'b1, 1'b0, 20'h00012);
        chk(mem_snooze, 1, "R5 snooze after drain");
        chk(mem_sel, 0, "R6 read blocked in snooze");
        chk(ready, 0, "R6 ready low in snooze");
        repeat (3) begin
            @(negedge clk); drive(1'b1, 1'b1, 20'h00013);
            chk(mem_snooze, 1, "R6 snooze held");
            chk(mem_sel, 0, "R6 write blocked in snooze");
        end

        // Wake and recovery (R8, R9, R10)
        @(negedge clk); sleep_req = 1'b0; #1;
        chk(mem_snooze, 1, "R8 pin until edge");
        @(negedge clk); drive(1'b1, 1'b1, 20'h00020);
        chk(mem_snooze, 0, "R8 pin released");
        chk(ready, 0, "R9 write stalled wake 1");
        chk(mem_sel, 0, "R9 write deselected wake 1");
        drive(1'b1, 1'b0, 20'h00021);
        chk(ready, 1, "R9 read ready wake 1");
        chk(mem_sel, 1, "R9 read passed wake 1");
        @(negedge clk); drive(1'b1, 1'b1, 20'h00022);
        chk(ready, 0, "R9 write stalled wake 2");
        chk(mem_sel, 0, "R9 write deselected wake 2");
        @(negedge clk); drive(1'b1, 1'b1, 20'h00022);
        chk(ready, 1, "R10 write accepted");
        chk(mem_sel, 1, "R10 write issued");
        chk(mem_wr, 1, "R10 write kind");

        // Aborted drain (R7)
        @(negedge clk); sleep_req = 1'b1; drive(1'b0, 1'b0, 20'h0);
        @(negedge clk); sleep_req = 1'b0; #1;
        chk(mem_snooze, 0, "R7 no snooze during abort");
        @(negedge clk); drive(1'b1, 1'b1, 20'h00030);
        chk(mem_snooze, 0, "R7 no snooze after abort");
        chk(ready, 1, "R7 run resumes");
        chk(mem_sel, 1, "R7 write passes");

        // Reset during snooze (R1)
        @(negedge clk); sleep_req = 1'b1;
        repeat (3) @(negedge clk);
        #1; chk(mem_snooze, 1, "R5 snooze before reset");
        rst_n = 1'b0; sleep_req = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk(mem_snooze, 0, "R1 reset clears snooze");
        chk(ready, 1, "R1 reset ready");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule